// File: doc/BRIEF.md
# Rank-Based Ready Instruction Picker

This block picks one instruction to issue each cycle from a fixed set of ready-queue slots. Every slot presents a valid bit, a program-order sequence number, a count of known consumers, and a flag saying its execution resources are free. The picker orders the eligible slots by a priority rank and reports the slot number of the winner one clock later. It does not store the slots, track dependencies or arbitrate for resources. Those jobs belong to the logic around it, which drives the slot fields every cycle.

The rank of a slot is its age minus its consumer count. Age is the distance of its sequence number from the oldest in-flight sequence number. A slot that many younger instructions wait on can therefore overtake an older slot with no consumers. Sequence numbers wrap around, so age is taken modulo the sequence space relative to `oldest_seq`.

The result is a plain registered output rather than a stream. `pick_vld` and `pick_idx` are updated on every rising clock edge from the slot inputs present at that edge. No back-pressure exists: the consumer either uses the pick in the cycle it is shown or ignores it. It may present fresh slot state in the same cycle. Configuration lives in package `rp_pkg`: `N_ENT` slots, `SEQ_W` sequence bits, `CNT_W` consumer-count bits with `CNT_W <= SEQ_W`, and `IDX_W = $clog2(N_ENT)`.

Top module: `rank_picker`

## Requirements
- R1: The rank of slot k is ((ent_seq[k] - oldest_seq) mod 2^SEQ_W) - ent_users[k], where ent_seq slot k occupies bits [k*SEQ_W +: SEQ_W] and ent_users slot k occupies bits [k*CNT_W +: CNT_W].
- R2: Among eligible slots, the one with the smallest rank is picked.
- R3: When ranks are equal, the slot with the smaller age (older instruction) is picked.
- R4: When rank and age are both equal, the lower slot number is picked.
- R5: A slot with ent_vld[k]=0 or ent_res_ok[k]=0 is never picked, whatever its rank.
- R6: When no slot is eligible, pick_vld is 0 after the next rising edge.
- R7: pick_vld and pick_idx reflect the slot inputs sampled at the latest rising edge and hold until the next edge (one cycle latency).
- R8: Age is measured from oldest_seq modulo 2^SEQ_W, so a sequence number that has wrapped past zero still counts as younger.
- R9: Ranks are signed; a consumer count larger than the age gives a negative rank, which beats any non-negative rank.
- R10: While rst_n is low, and after its release until the first rising edge, pick_vld is 0 and pick_idx is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| oldest_seq | input | SEQ_W | Sequence number of the oldest in-flight instruction |
| ent_vld | input | N_ENT | Slot holds a ready instruction, one bit per slot |
| ent_res_ok | input | N_ENT | Slot's execution resources are free, one bit per slot |
| ent_seq | input | N_ENT*SEQ_W | Packed per-slot sequence numbers |
| ent_users | input | N_ENT*CNT_W | Packed per-slot known consumer counts |
| pick_vld | output | 1 | A slot was selected |
| pick_idx | output | IDX_W | Slot number of the selected instruction |

## Verification
The picker holds no state apart from its output register, so any internal fault shows on `pick_idx` or `pick_vld` in the first cycle after the offending slot pattern. A wrong age subtraction, a rank truncated to unsigned, or a compare stage that prefers the wrong child shows as a different slot number right after that edge. A broken eligibility mask shows as a pick of a masked slot, or as a stuck-low `pick_vld`. Directed patterns isolate each tie-break level, wrap-around and negative ranks. A long run of random patterns is then compared against a linear scan of the slot inputs.

// File: rtl/rp_pkg.sv
package rp_pkg;
  parameter int N_ENT  = 8;
  parameter int SEQ_W  = 6;
  parameter int CNT_W  = 3;
  localparam int IDX_W  = $clog2(N_ENT);
  localparam int RANK_W = SEQ_W + 1;
  localparam int LEAVES = 1 << IDX_W;

  typedef struct packed {
    logic                     vld;
    logic signed [RANK_W-1:0] rank;
    logic [SEQ_W-1:0]         age;
    logic [IDX_W-1:0]         slot;
  } cand_t;
endpackage

// File: rtl/rp_rank_calc.sv
module rp_rank_calc
  import rp_pkg::*;
#(
  parameter int SLOT = 0
) (
  input  logic [SEQ_W-1:0] oldest,
  input  logic             vld,
  input  logic             res_ok,
  input  logic [SEQ_W-1:0] seq,
  input  logic [CNT_W-1:0] users,
  output cand_t            cand
);
  logic [SEQ_W-1:0]         age;
  logic signed [RANK_W-1:0] age_s;
  logic signed [RANK_W-1:0] users_s;

  always_comb begin
    age     = seq - oldest;
    age_s   = $signed({1'b0, age});
    users_s = $signed({{(RANK_W-CNT_W){1'b0}}, users});
    cand.vld  = vld & res_ok;
    cand.rank = age_s - users_s;
    cand.age  = age;
    cand.slot = IDX_W'(SLOT);
  end
endmodule

// File: rtl/rp_cmp_sel.sv
module rp_cmp_sel
  import rp_pkg::*;
(
  input  cand_t lo,
  input  cand_t hi,
  output cand_t win
);
  logic take_hi;
  logic rank_lt, rank_eq, age_lt;

  always_comb begin
    rank_lt = $signed(hi.rank) < $signed(lo.rank);
    rank_eq = hi.rank == lo.rank;
    age_lt  = hi.age < lo.age;
    if (!hi.vld)      take_hi = 1'b0;
    else if (!lo.vld) take_hi = 1'b1;
    else              take_hi = rank_lt | (rank_eq & age_lt);
    win = take_hi ? hi : lo;
  end
endmodule

// File: rtl/rank_picker.sv
module rank_picker
  import rp_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SEQ_W-1:0]       oldest_seq,
  input  logic [N_ENT-1:0]       ent_vld,
  input  logic [N_ENT-1:0]       ent_res_ok,
  input  logic [N_ENT*SEQ_W-1:0] ent_seq,
  input  logic [N_ENT*CNT_W-1:0] ent_users,
  output logic                   pick_vld,
  output logic [IDX_W-1:0]       pick_idx
);
  cand_t leaf [LEAVES];
  cand_t node [LEAVES-1];

  for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
    if (k < N_ENT) begin : g_real
      rp_rank_calc #(.SLOT(k)) u_rank (
        .oldest (oldest_seq),
        .vld    (ent_vld[k]),
        .res_ok (ent_res_ok[k]),
        .seq    (ent_seq[k*SEQ_W +: SEQ_W]),
        .users  (ent_users[k*CNT_W +: CNT_W]),
        .cand   (leaf[k])
      );
    end else begin : g_pad
      assign leaf[k] = '0;
    end
  end

  // Heap-ordered tree: node i takes children 2i+1 and 2i+2; indices past
  // the internal range map onto leaves. Left child always holds lower slots.
  for (genvar i = 0; i < LEAVES-1; i++) begin : g_node
    cand_t a_in, b_in;
    if (2*i+1 >= LEAVES-1) begin : g_from_leaf
      assign a_in = leaf[2*i+1-(LEAVES-1)];
      assign b_in = leaf[2*i+2-(LEAVES-1)];
    end else begin : g_from_node
      assign a_in = node[2*i+1];
      assign b_in = node[2*i+2];
    end
    rp_cmp_sel u_sel (.lo(a_in), .hi(b_in), .win(node[i]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pick_vld <= 1'b0;
      pick_idx <= '0;
    end else begin
      pick_vld <= node[0].vld;
      pick_idx <= node[0].slot;
    end
  end

  // Root of the tree against every leaf.
  always_comb begin
    if (rst_n && node[0].vld) begin
      for (int k = 0; k < N_ENT; k++) begin
        if (leaf[k].vld) begin
          AST_ROOT_MIN_RANK: assert ($signed(node[0].rank) <= $signed(leaf[k].rank)) else $error("root rank above leaf"); // R2
          if (node[0].rank == leaf[k].rank) begin
            AST_TIE_OLDER: assert (node[0].age <= leaf[k].age) else $error("tie not older"); // R3
            if (node[0].age == leaf[k].age) begin
              AST_TIE_SLOT: assert (node[0].slot <= leaf[k].slot) else $error("tie not lower slot"); // R4
            end
          end
        end
      end
    end
  end

  AST_PICK_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    pick_vld |-> |($past(ent_vld & ent_res_ok) & (N_ENT'(1) << pick_idx))) else $error("masked slot picked"); // R5
  AST_NONE_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(ent_vld & ent_res_ok)) |=> !pick_vld) else $error("pick without eligible slot"); // R6
  AST_ANY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ent_vld & ent_res_ok)) |=> pick_vld) else $error("eligible slot not picked"); // R7
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pick_vld |-> (int'(pick_idx) < N_ENT)) else $error("index out of range"); // R5
endmodule

// File: tb/sim_rank_picker.sv
`timescale 1ns/1ps
module sim_rank_picker;
  import rp_pkg::*;

  logic                   clk = 1'b0;
  logic                   rst_n;
  logic [SEQ_W-1:0]       oldest_seq;
  logic [N_ENT-1:0]       ent_vld, ent_res_ok;
  logic [N_ENT*SEQ_W-1:0] ent_seq;
  logic [N_ENT*CNT_W-1:0] ent_users;
  logic                   pick_vld;
  logic [IDX_W-1:0]       pick_idx;

  logic [SEQ_W-1:0] s_seq [N_ENT];
  logic [CNT_W-1:0] s_usr [N_ENT];

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  always_comb begin
    for (int k = 0; k < N_ENT; k++) begin
      ent_seq[k*SEQ_W +: SEQ_W] = s_seq[k];
      ent_users[k*CNT_W +: CNT_W] = s_usr[k];
    end
  end

  rank_picker u0 (
    .clk(clk), .rst_n(rst_n), .oldest_seq(oldest_seq),
    .ent_vld(ent_vld), .ent_res_ok(ent_res_ok),
    .ent_seq(ent_seq), .ent_users(ent_users),
    .pick_vld(pick_vld), .pick_idx(pick_idx)
  );

  task automatic chk(input string req, input int exp_v, input int exp_i);
    checks++;
    if (int'(pick_vld) != exp_v || (exp_v == 1 && int'(pick_idx) != exp_i)) begin
      errors++;
      $display("FAIL %s: got vld=%0d idx=%0d, expected vld=%0d idx=%0d",
               req, pick_vld, pick_idx, exp_v, exp_i);
    end
  endtask

  task automatic clear_all();
    ent_vld = '0; ent_res_ok = '0; oldest_seq = '0;
    for (int k = 0; k < N_ENT; k++) begin s_seq[k] = '0; s_usr[k] = '0; end
  endtask

  task automatic put(input int k, input int seq, input int usr);
    ent_vld[k] = 1'b1; ent_res_ok[k] = 1'b1;
    s_seq[k] = SEQ_W'(seq); s_usr[k] = CNT_W'(usr);
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // Linear reference scan from the requirement text.
  task automatic model(output int mv, output int mi);
    int br, ba, r, a;
    mv = 0; mi = 0; br = 0; ba = 0;
    for (int k = 0; k < N_ENT; k++) begin
      if (ent_vld[k] && ent_res_ok[k]) begin
        a = int'(SEQ_W'(s_seq[k] - oldest_seq));
        r = a - int'(s_usr[k]);
        if (!mv || r < br || (r == br && a < ba)) begin
          mv = 1; mi = k; br = r; ba = a;
        end
      end
    end
  endtask

  task automatic t_reset();
    clear_all(); put(3, 1, 0); rst_n = 1'b0;
    #9; chk("R10 during reset", 0, 0);
    checks++; if (pick_idx !== '0) begin errors++; $display("FAIL R10: idx=%0d expected 0", pick_idx); end
    @(negedge clk); rst_n = 1'b1; #0.5; chk("R10 after release", 0, 0);
  endtask

  task automatic t_rank();
    @(negedge clk); clear_all();
    put(0, 5, 0); put(1, 7, 4); put(2, 4, 0);
    step(); chk("R1/R2 lowest rank", 1, 1);
  endtask

  task automatic t_tie_age();
    @(negedge clk); clear_all();
    put(3, 9, 3); put(5, 8, 2);
    step(); chk("R3 equal rank older wins", 1, 5);
  endtask

  task automatic t_tie_slot();
    @(negedge clk); clear_all();
    put(6, 10, 1); put(2, 10, 1);
    step(); chk("R4 full tie lower slot", 1, 2);
  endtask

  task automatic t_mask();
    @(negedge clk); clear_all();
    put(0, 0, 7); ent_res_ok[0] = 1'b0;
    put(4, 1, 7); ent_vld[4] = 1'b0;
    put(7, 30, 0);
    step(); chk("R5 masked slots skipped", 1, 7);
    @(negedge clk); ent_res_ok[0] = 1'b1;
    step(); chk("R5 unmasked slot wins", 1, 0);
  endtask

  task automatic t_none();
    @(negedge clk); clear_all();
    for (int k = 0; k < N_ENT; k++) put(k, k, 0);
    ent_res_ok = '0;
    step(); chk("R6 no resources", 0, 0);
    @(negedge clk); ent_res_ok = '1; ent_vld = '0;
    step(); chk("R6 no valid", 0, 0);
  endtask

  task automatic t_wrap();
    @(negedge clk); clear_all(); oldest_seq = SEQ_W'(60);
    put(0, 1, 0); put(1, 62, 0);
    step(); chk("R8 wrapped seq is younger", 1, 1);
  endtask

  task automatic t_neg();
    @(negedge clk); clear_all();
    put(3, 63, 0); put(4, 2, 7); put(1, 0, 0);
    step(); chk("R9 negative rank wins", 1, 4);
  endtask

  task automatic t_latency();
    @(negedge clk); clear_all();
    put(2, 3, 0); put(5, 6, 0);
    step(); chk("R7 first pick", 1, 2);
    @(negedge clk); ent_vld[2] = 1'b0;
    #0.5; chk("R7 held until edge", 1, 2);
    step(); chk("R7 new pick after edge", 1, 5);
  endtask

  task automatic t_random();
    int mv, mi;
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      oldest_seq = SEQ_W'($urandom);
      ent_vld = N_ENT'($urandom); ent_res_ok = N_ENT'($urandom | $urandom);
      for (int k = 0; k < N_ENT; k++) begin
        s_seq[k] = SEQ_W'($urandom); s_usr[k] = CNT_W'($urandom);
      end
      model(mv, mi);
      step(); chk("R1/R2/R3 random vs scan", mv, mi);
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_rank();
    t_tie_age();
    t_tie_slot();
    t_mask();
    t_none();
    t_wrap();
    t_neg();
    t_latency();
    t_random();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule